// File: doc/BRIEF.md
# Clock Output Mode and Gating Controller

This block sits between the clock sources of a system clock generator and its output pads. For every output pin it decides what the pin carries. In normal operation the pin carries its regular clock from the frequency synthesizers. In test mode the synthesizers are bypassed and the pin carries a clock divided down from the crystal input. The pin can also be held actively low, or released to high impedance. The choice comes from four configuration bytes, which a serial configuration port upstream writes into the block's input pins.

Each output has its own enable bit. A disabled output is driven low, not floated. The enable register of an output is clocked on the falling edge of that output's selected source, so a change of enable never cuts a high phase short. A 2-bit mode field selects normal, bypass test, spread-spectrum, or all-outputs-floating. The floating mode overrides every enable.

The block also tells the frequency logic where the CPU/PCI frequency comes from: either the external speed-select pin, or a 4-bit table index held in the configuration. It provides a separate spread-enable flag for the modulation logic. The frequency table itself and the modulation are not part of this block.

The output index order is fixed as follows. Index 0 is CPU0 and index 1 is CPU1. Index 2 is the free-running PCI clock and indices 3 to 8 are PCI1 to PCI6. Index 9 is IOAPIC and index 10 is REF. Index 11 is the 24/48 MHz output and index 12 is the fixed 48 MHz output.

Top module: `cgc_clk_ctrl`

## Requirements
- R1: Mode field cfg_b3[1:0] set to 00 or 10 routes each output's normal source (CPU from clk_cpu_pll, PCI from clk_pci_pll, IOAPIC and REF from clk_x1, 24/48 from clk_sel2448, 48 from clk_usb48); spread_en is 1 only for 10.
- R2: Mode field 01 routes crystal-derived clocks: CPU and 48 outputs get X1/2, IOAPIC and REF get X1, the 24/48 output gets X1/4, and the PCI outputs get X1/(2*N) with N=2,3,4 for pci_ratio 0,1,2 (3 also gives 4).
- R3: Mode field 11 drives every bit of clk_oe to 0, whatever the enable bits hold.
- R4: Enable bits, 1 = run and 0 = held low while still driven: cfg_b4[0] CPU0, cfg_b4[1] CPU1, cfg_b4[6] 24/48, cfg_b5[7] PCI free-running, cfg_b5[0..3] PCI1..PCI4, cfg_b5[5] PCI5, cfg_b5[6] PCI6, cfg_b6[4] IOAPIC; the 48 MHz output has no enable bit.
- R5: The REF output runs only when both cfg_b6[1] and cfg_b6[0] are 1; if either is 0 it is held low.
- R6: Reserved bits (cfg_b3[2], cfg_b4[7], cfg_b4[5:2], cfg_b5[4], cfg_b6[7:5], cfg_b6[3:2]) have no effect on any output.
- R7: cfg_b3[3]=1 gives freq_reg_sel=1, freq_idx=cfg_b3[7:4], freq_pin_hi=0; cfg_b3[3]=0 gives freq_reg_sel=0, freq_idx=0, freq_pin_hi=sel_pin.
- R8: An enable change takes effect only while the output's source is low, so every high pulse on an output has the full high time of its source.
- R9: While rst_n is low every clock output is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset, released in step with clk_x1 |
| clk_x1 | input | 1 | Crystal reference clock |
| clk_cpu_pll | input | 1 | Normal CPU clock from the synthesizer |
| clk_pci_pll | input | 1 | Normal PCI clock from the synthesizer |
| clk_usb48 | input | 1 | Fixed 48 MHz clock |
| clk_sel2448 | input | 1 | 24 or 48 MHz clock picked at power-up |
| sel_pin | input | 1 | External speed-select pin level |
| pci_ratio | input | 2 | Test-mode PCI divide choice |
| cfg_b3 | input | 8 | Mode and frequency-select byte |
| cfg_b4 | input | 8 | CPU and 24/48 enable byte |
| cfg_b5 | input | 8 | PCI enable byte |
| cfg_b6 | input | 8 | IOAPIC and REF enable byte |
| clk_out | output | 13 | Gated output clocks, index order as above |
| clk_oe | output | 13 | Pad drive enable per output, 0 = high impedance |
| spread_en | output | 1 | Spread modulation request |
| freq_reg_sel | output | 1 | 1 = frequency from the table index |
| freq_idx | output | 4 | Table index, 0 when the pin selects |
| freq_pin_hi | output | 1 | Pin requests the higher CPU speed |

## Verification
The assertions assume three things about the inputs: the configuration bytes change only at rates far below the clocks, rst_n is already synchronized to clk_x1, and every source clock keeps toggling, so that a pending enable change can reach the output. The bench meets these assumptions. It changes the bytes only between measurement windows, with a settling time longer than the slowest divided period. It releases reset in step with the crystal clock, and it runs all five sources from free-running generators for the whole run. The one deliberate break in this pattern is the glitch test. That test toggles an enable in the middle of a high phase to exercise the falling-edge capture.

// File: rtl/cgc_pkg.sv
`timescale 1ns/100ps
package cgc_pkg;
  localparam int NUM_OUT   = 13;
  localparam int O_CPU0    = 0;
  localparam int O_CPU1    = 1;
  localparam int O_PCIF    = 2;
  localparam int O_PCI1    = 3;
  localparam int O_PCI6    = 8;
  localparam int O_IOAPIC  = 9;
  localparam int O_REF     = 10;
  localparam int O_SELBL   = 11;
  localparam int O_USB     = 12;
  localparam int PCI_CNT_W = 3;
  localparam int IDX_W     = 4;

  // configuration bit positions decoded by this block
  localparam int B3_SRC    = 3;
  localparam int B3_IDX_LO = 4;
  localparam int B4_CPU0   = 0;
  localparam int B4_CPU1   = 1;
  localparam int B4_SELBL  = 6;
  localparam int B5_PCIF   = 7;
  localparam int B6_IOAPIC = 4;
  localparam int B6_REF_A  = 1;
  localparam int B6_REF_B  = 0;

  typedef enum logic [1:0] {
    MODE_NORM   = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_HIZ    = 2'b11
  } out_mode_e;
endpackage

// File: rtl/cgc_mode_dec.sv
`timescale 1ns/100ps
module cgc_mode_dec
  import cgc_pkg::*;
(
  input  logic [7:0]         cfg_b3,
  input  logic [7:0]         cfg_b4,
  input  logic [7:0]         cfg_b5,
  input  logic [7:0]         cfg_b6,
  input  logic               sel_pin,
  output logic               test_mode,
  output logic               hiz_mode,
  output logic               spread_en,
  output logic [NUM_OUT-1:0] en_vec,
  output logic               freq_reg_sel,
  output logic [IDX_W-1:0]   freq_idx,
  output logic               freq_pin_hi
);
  out_mode_e mode;

  always_comb begin
    mode      = out_mode_e'(cfg_b3[1:0]);
    test_mode = (mode == MODE_TEST);
    hiz_mode  = (mode == MODE_HIZ);
    spread_en = (mode == MODE_SPREAD);
  end

  // per-output enables; PCI5 sits above a reserved bit
  always_comb begin
    en_vec            = '0;
    en_vec[O_CPU0]    = cfg_b4[B4_CPU0];
    en_vec[O_CPU1]    = cfg_b4[B4_CPU1];
    en_vec[O_PCIF]    = cfg_b5[B5_PCIF];
    en_vec[O_PCI1+0]  = cfg_b5[0];
    en_vec[O_PCI1+1]  = cfg_b5[1];
    en_vec[O_PCI1+2]  = cfg_b5[2];
    en_vec[O_PCI1+3]  = cfg_b5[3];
    en_vec[O_PCI1+4]  = cfg_b5[5];
    en_vec[O_PCI6]    = cfg_b5[6];
    en_vec[O_IOAPIC]  = cfg_b6[B6_IOAPIC];
    en_vec[O_REF]     = cfg_b6[B6_REF_A] & cfg_b6[B6_REF_B];
    en_vec[O_SELBL]   = cfg_b4[B4_SELBL];
    en_vec[O_USB]     = 1'b1;
  end

  always_comb begin
    freq_reg_sel = cfg_b3[B3_SRC];
    freq_idx     = freq_reg_sel ? cfg_b3[B3_IDX_LO +: IDX_W] : '0;
    freq_pin_hi  = ~freq_reg_sel & sel_pin;
  end
endmodule

// File: rtl/cgc_test_div.sv
`timescale 1ns/100ps
module cgc_test_div
  import cgc_pkg::*;
#(
  parameter int CW = PCI_CNT_W
)(
  input  logic       clk_x1,
  input  logic       rst_n,
  input  logic [1:0] pci_ratio,
  output logic       x1_div2,
  output logic       x1_div4,
  output logic       pci_tst
);
  logic [1:0]    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d, half_m1;
  logic          pci_q, pci_d;

  always_comb begin
    unique case (pci_ratio)
      2'd0:    half_m1 = CW'(1);
      2'd1:    half_m1 = CW'(2);
      default: half_m1 = CW'(3);
    endcase
  end

  always_comb begin
    ph_d = ph_q + 2'd1;
    if (cnt_q >= half_m1) begin
      cnt_d = '0;
      pci_d = ~pci_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
      pci_d = pci_q;
    end
  end

  always_ff @(posedge clk_x1 or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      cnt_q <= '0;
      pci_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      pci_q <= pci_d;
    end
  end

  assign x1_div2 = ph_q[0];
  assign x1_div4 = ph_q[1];
  assign pci_tst = pci_q;

  AST_DIV4_ON_DIV2_FALL: assert property (@(posedge clk_x1) disable iff (!rst_n)
    $rose(x1_div4) |-> $fell(x1_div2)); // R2
  AST_PCI_MIN_HIGH: assert property (@(posedge clk_x1) disable iff (!rst_n)
    $rose(pci_tst) |=> pci_tst); // R2
endmodule

// File: rtl/cgc_out_gate.sv
`timescale 1ns/100ps
module cgc_out_gate (
  input  logic rst_n,
  input  logic src_norm,
  input  logic src_test,
  input  logic test_mode,
  input  logic hiz_mode,
  input  logic en,
  output logic clk_o,
  output logic oe_o
);
  logic src;
  logic en_q;

  assign src = test_mode ? src_test : src_norm;

  // capture the enable only while the source is low
  always_ff @(negedge src or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign clk_o = src & en_q;
  assign oe_o  = ~hiz_mode;
endmodule

// File: rtl/cgc_clk_ctrl.sv
`timescale 1ns/100ps
module cgc_clk_ctrl
  import cgc_pkg::*;
(
  input  logic               rst_n,
  input  logic               clk_x1,
  input  logic               clk_cpu_pll,
  input  logic               clk_pci_pll,
  input  logic               clk_usb48,
  input  logic               clk_sel2448,
  input  logic               sel_pin,
  input  logic [1:0]         pci_ratio,
  input  logic [7:0]         cfg_b3,
  input  logic [7:0]         cfg_b4,
  input  logic [7:0]         cfg_b5,
  input  logic [7:0]         cfg_b6,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_oe,
  output logic               spread_en,
  output logic               freq_reg_sel,
  output logic [IDX_W-1:0]   freq_idx,
  output logic               freq_pin_hi
);
  logic               test_mode, hiz_mode;
  logic [NUM_OUT-1:0] en_vec;
  logic               x1_div2, x1_div4, pci_tst;

  cgc_mode_dec u_dec (
    .cfg_b3(cfg_b3), .cfg_b4(cfg_b4), .cfg_b5(cfg_b5), .cfg_b6(cfg_b6),
    .sel_pin(sel_pin), .test_mode(test_mode), .hiz_mode(hiz_mode),
    .spread_en(spread_en), .en_vec(en_vec), .freq_reg_sel(freq_reg_sel),
    .freq_idx(freq_idx), .freq_pin_hi(freq_pin_hi)
  );

  cgc_test_div #(.CW(PCI_CNT_W)) u_div (
    .clk_x1(clk_x1), .rst_n(rst_n), .pci_ratio(pci_ratio),
    .x1_div2(x1_div2), .x1_div4(x1_div4), .pci_tst(pci_tst)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic s_norm, s_test;
    if (g <= O_CPU1) begin : g_cpu
      assign s_norm = clk_cpu_pll;
      assign s_test = x1_div2;
    end else if (g <= O_PCI6) begin : g_pci
      assign s_norm = clk_pci_pll;
      assign s_test = pci_tst;
    end else if (g <= O_REF) begin : g_ref
      assign s_norm = clk_x1;
      assign s_test = clk_x1;
    end else if (g == O_SELBL) begin : g_sel
      assign s_norm = clk_sel2448;
      assign s_test = x1_div4;
    end else begin : g_usb
      assign s_norm = clk_usb48;
      assign s_test = x1_div2;
    end

    cgc_out_gate u_gate (
      .rst_n(rst_n), .src_norm(s_norm), .src_test(s_test),
      .test_mode(test_mode), .hiz_mode(hiz_mode), .en(en_vec[g]),
      .clk_o(clk_out[g]), .oe_o(clk_oe[g])
    );
  end

  AST_TRI_OVERRIDE: assert property (@(posedge clk_x1) disable iff (!rst_n)
    (cfg_b3[1:0] == 2'b11) |-> (clk_oe == '0)); // R3
  AST_SPREAD_DRIVEN: assert property (@(posedge clk_x1) disable iff (!rst_n)
    spread_en |-> (clk_oe == '1)); // R1
  AST_PIN_IDX_ZERO: assert property (@(posedge clk_x1) disable iff (!rst_n)
    !cfg_b3[3] |-> (freq_idx == '0 && !freq_reg_sel)); // R7
  AST_REG_NO_PIN: assert property (@(posedge clk_x1) disable iff (!rst_n)
    freq_reg_sel |-> !freq_pin_hi); // R7
endmodule

// File: tb/cgc_clk_ctrl_bench.sv
`timescale 1ns/100ps
module cgc_clk_ctrl_bench;
  import cgc_pkg::*;

  localparam real CLK_PERIOD = 10.0;
  localparam int  SETTLE     = 100;
  localparam int  WIN        = 300;
  localparam int  HIZ_CODE   = 255;

  logic rst_n, clk_x1, clk_cpu_pll, clk_pci_pll, clk_usb48, clk_sel2448, sel_pin;
  logic [1:0] pci_ratio;
  logic [7:0] cfg_b3, cfg_b4, cfg_b5, cfg_b6;
  logic [NUM_OUT-1:0] clk_out, clk_oe;
  logic spread_en, freq_reg_sel, freq_pin_hi;
  logic [IDX_W-1:0] freq_idx;

  cgc_clk_ctrl u_cgc_clk_ctrl (.*);

  typedef struct packed {
    logic [NUM_OUT-1:0][7:0] per;
    logic                    spr;
    logic                    rsel;
    logic                    phi;
    logic [3:0]              idx;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int    n_chk, n_fail, push_cnt, done_cnt;

  initial clk_x1 = 1'b0;
  always #(CLK_PERIOD/2) clk_x1 = ~clk_x1;
  initial clk_cpu_pll = 1'b0;
  always #3 clk_cpu_pll = ~clk_cpu_pll;
  initial clk_pci_pll = 1'b0;
  always #9 clk_pci_pll = ~clk_pci_pll;
  initial clk_usb48 = 1'b0;
  always #2 clk_usb48 = ~clk_usb48;
  initial clk_sel2448 = 1'b0;
  always #4 clk_sel2448 = ~clk_sel2448;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected period (ns) per output from the requirements; 0 = held low
  function automatic exp_t model(input logic [7:0] b3, b4, b5, b6,
                                 input logic [1:0] rat, input logic sp);
    exp_t e;
    logic tst;
    int n;
    logic [NUM_OUT-1:0] en;
    tst = (b3[1:0] == 2'b01);
    n = (rat == 2'd0) ? 2 : (rat == 2'd1) ? 3 : 4;
    en = {1'b1, b4[6], b6[1] & b6[0], b6[4], b5[6], b5[5], b5[3], b5[2],
          b5[1], b5[0], b5[7], b4[1], b4[0]};
    for (int i = 0; i < NUM_OUT; i++) begin
      int p;
      if (i <= O_CPU1)       p = tst ? 20 : 6;
      else if (i <= O_PCI6)  p = tst ? 20 * n : 18;
      else if (i <= O_REF)   p = 10;
      else if (i == O_SELBL) p = tst ? 40 : 8;
      else                   p = tst ? 20 : 4;
      if (b3[1:0] == 2'b11) e.per[i] = 8'(HIZ_CODE);
      else if (!en[i])      e.per[i] = 8'd0;
      else                  e.per[i] = 8'(p);
    end
    e.spr  = (b3[1:0] == 2'b10);
    e.rsel = b3[3];
    e.idx  = b3[3] ? b3[7:4] : 4'd0;
    e.phi  = !b3[3] && sp;
    return e;
  endfunction

  task automatic apply(input logic [7:0] b3, b4, b5, b6, input logic [1:0] rat,
                       input logic sp, input string req);
    cfg_b3 = b3; cfg_b4 = b4; cfg_b5 = b5; cfg_b6 = b6;
    pci_ratio = rat; sel_pin = sp;
    exp_q.push_back(model(b3, b4, b5, b6, rat, sp));
    req_q.push_back(req);
    push_cnt++;
    wait (done_cnt == push_cnt);
  endtask

  // monitor: pops expectations, measures every output over a window
  initial begin
    exp_t  e;
    string r;
    int    first_t [NUM_OUT];
    int    per_m   [NUM_OUT];
    logic  prev    [NUM_OUT];
    logic  saw_hi  [NUM_OUT];
    logic  oe_lo   [NUM_OUT];
    forever begin
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      r = req_q.pop_front();
      #(SETTLE);
      check("R1", "spread_en", int'(spread_en), int'(e.spr));
      check("R7", "freq_reg_sel", int'(freq_reg_sel), int'(e.rsel));
      check("R7", "freq_idx", int'(freq_idx), int'(e.idx));
      check("R7", "freq_pin_hi", int'(freq_pin_hi), int'(e.phi));
      for (int i = 0; i < NUM_OUT; i++) begin
        first_t[i] = -1; per_m[i] = -1; prev[i] = clk_out[i];
        saw_hi[i] = 1'b0; oe_lo[i] = 1'b0;
      end
      for (int t = 0; t < WIN; t++) begin
        for (int i = 0; i < NUM_OUT; i++) begin
          if (!clk_oe[i]) oe_lo[i] = 1'b1;
          if (clk_out[i]) saw_hi[i] = 1'b1;
          if (clk_out[i] && !prev[i]) begin
            if (first_t[i] < 0)     first_t[i] = t;
            else if (per_m[i] < 0)  per_m[i] = t - first_t[i];
          end
          prev[i] = clk_out[i];
        end
        #1;
      end
      for (int i = 0; i < NUM_OUT; i++) begin
        int act;
        if (oe_lo[i])        act = HIZ_CODE;
        else if (!saw_hi[i]) act = 0;
        else if (per_m[i] < 0) act = 254;
        else                 act = per_m[i];
        check(r, $sformatf("output %0d period", i), act, int'(e.per[i]));
      end
      done_cnt++;
    end
  end

  // R8: toggle an enable inside the high phase; every pulse must stay full width
  task automatic glitch_test();
    int min_run, max_run, run, pulses;
    logic seen_low;
    cfg_b3 = 8'h00; cfg_b4 = 8'h01; cfg_b5 = 8'h00; cfg_b6 = 8'h00;
    #(SETTLE);
    min_run = 1000; max_run = 0; run = 0; pulses = 0; seen_low = 1'b0;
    fork
      begin
        repeat (12) begin
          @(posedge clk_cpu_pll);
          #1.2;
          cfg_b4[0] = ~cfg_b4[0];
        end
      end
      begin
        repeat (150) begin
          if (clk_out[O_CPU0]) begin
            if (seen_low) run++;
          end else begin
            seen_low = 1'b1;
            if (run > 0) begin
              pulses++;
              if (run < min_run) min_run = run;
              if (run > max_run) max_run = run;
              run = 0;
            end
          end
          #1;
        end
      end
    join
    check("R8", "pulses seen", int'(pulses > 0), 1);
    check("R8", "shortest high pulse samples", min_run, 3);
    check("R8", "longest high pulse samples", max_run, 3);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; push_cnt = 0; done_cnt = 0;
    rst_n = 1'b0; sel_pin = 1'b0; pci_ratio = 2'd0;
    cfg_b3 = 8'h00; cfg_b4 = 8'hFF; cfg_b5 = 8'hFF; cfg_b6 = 8'hFF;
    #20.5;
    begin
      int highs;
      highs = 0;
      repeat (20) begin
        if (clk_out != '0) highs++;
        #1;
      end
      check("R9", "samples with an output high in reset", highs, 0);
    end
    rst_n = 1'b1;

    apply(8'h00, 8'hFF, 8'hFF, 8'hFF, 2'd0, 1'b0, "R1");
    apply(8'hA2, 8'hFF, 8'hFF, 8'hFF, 2'd0, 1'b1, "R1");
    apply(8'h01, 8'hFF, 8'hFF, 8'hFF, 2'd0, 1'b0, "R2");
    apply(8'h01, 8'hFF, 8'hFF, 8'hFF, 2'd1, 1'b0, "R2");
    apply(8'h59, 8'h42, 8'hA5, 8'h13, 2'd2, 1'b1, "R2");
    apply(8'h03, 8'h00, 8'h00, 8'h00, 2'd0, 1'b0, "R3");
    apply(8'h03, 8'hFF, 8'hFF, 8'hFF, 2'd1, 1'b1, "R3");
    apply(8'h00, 8'h41, 8'hA5, 8'h13, 2'd0, 1'b0, "R4");
    apply(8'h00, 8'h02, 8'h5A, 8'h00, 2'd0, 1'b1, "R4");
    apply(8'h00, 8'hFF, 8'hFF, 8'h12, 2'd0, 1'b0, "R5");
    apply(8'h00, 8'hFF, 8'hFF, 8'h11, 2'd0, 1'b0, "R5");
    apply(8'h04, 8'hBC, 8'h10, 8'hEC, 2'd0, 1'b0, "R6");
    apply(8'hF8, 8'hFF, 8'hFF, 8'hFF, 2'd0, 1'b1, "R7");
    apply(8'h00, 8'h43, 8'hEF, 8'h13, 2'd0, 1'b1, "R7");
    glitch_test();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule